// File: doc/BRIEF.md
# Indirect-Register Host Bus Interface

This block is the byte-wide host-side register slave of a telephony and audio controller. The host sees a small window of direct byte offsets. Most control state lives in a larger indirect space. To reach it, the host writes a register number to the command location and then reads or writes the data location. Registers that are sixteen bits wide take two data accesses in a row, low byte first, and an internal byte sequencer tracks which half comes next.

The block holds four sixteen-bit gain words, two mode bytes, an init byte and a multiplexer control byte, and drives all of them out to the datapath. It also owns a pending-interrupt mask and a one-byte B-channel buffer pair. A read of the mask returns it and clears it. A sample tick moves the buffer contents in both directions and flags the B-channel source. The interrupt line combines the pending bits, the init state and the B-channel enable.

Top module: `hbi_top`

## Requirements
- R1: After reset every gain word, mode byte, init byte and multiplexer byte is zero, no interrupt is pending, `irq` is low and reads of every direct offset return 0x00.
- R2: A write to direct offset 0 selects the indirect register named by the written byte and returns the byte sequencer to the low byte, even when the previous access left it on the high byte.
- R3: The gain registers 0x63 (`gain_tx`), 0x64 (`gain_rx`), 0x65 (`gain_ext`) and 0x66 (`gain_side`) are each loaded by two data writes at offset 1, low byte first and then high byte. They read back through offset 1 in the same order, and a gain word does not change without a data write to it.
- R4: A third consecutive data access to a sixteen-bit register acts on the low byte again.
- R5: The one-byte registers 0x69 (`mode_a`), 0x6A (`mode_b`), 0x21 (init) and 0x44 (multiplexer control) each take a single data write and read back through offset 1.
- R6: A data read of an indirect register number that is not implemented returns 0x00, and a data write to one changes no implemented register.
- R7: A read of direct offset 0 returns the pending mask (bit 4 B-channel transfer, bit 0 D-channel transmit threshold, bit 1 D-channel receive threshold) and clears it. An event that arrives in the same cycle as that read stays pending.
- R8: A pulse on `sample_tick` sets pending bit 4, captures `rx_sample` into the receive buffer read at direct offset 5, and copies the transmit buffer last written at direct offset 5 to `tx_hold`.
- R9: `irq` is high only while the init byte reads 0x01 in its low two bits with bit 2 clear (0x00 idle, 0x01 active, 0x05 active with interrupts off) and a source is pending. B-channel pending counts only while bit 3 (0x08) of the multiplexer byte is set, and the D-channel bits always count.
- R10: After a read of offset 0 with no new event, `irq` is low from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Host access strobe for this block |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | 3 | Direct byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read |
| evt_dtx | input | 1 | D-channel transmit threshold event |
| evt_drx | input | 1 | D-channel receive threshold event |
| sample_tick | input | 1 | B-channel sample strobe |
| rx_sample | input | 8 | Incoming B-channel byte |
| tx_hold | output | 8 | Outgoing B-channel byte for the serializer |
| gain_tx | output | 16 | Transmit gain word |
| gain_rx | output | 16 | Receive gain word |
| gain_ext | output | 16 | Extra receive gain word |
| gain_side | output | 16 | Sidetone gain word |
| mode_a | output | 8 | First mode byte |
| mode_b | output | 8 | Second mode byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench goes after the byte sequencer. It leaves the sequencer on the high byte and then issues a new command, which a design that forgot the reset would answer by writing the low byte into the high half. It also makes a third access, where a design that saturated instead of wrapping would keep overwriting the high byte. The bench raises an event in the same cycle as the mask read, and a design that let the clear win would lose it. The bench also walks the init and multiplexer combinations. In these, a design that ignored the disable bit or masked the D-channel sources would raise or drop `irq` in the wrong state.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam int GW = 2 * DW;
    localparam int NGAIN = 4;

    localparam logic [AW-1:0] OFS_CMD  = 3'd0;
    localparam logic [AW-1:0] OFS_DATA = 3'd1;
    localparam logic [AW-1:0] OFS_BBUF = 3'd5;

    localparam logic [DW-1:0] RN_INIT  = 8'h21;
    localparam logic [DW-1:0] RN_MUX   = 8'h44;
    localparam logic [DW-1:0] RN_GAIN0 = 8'h63;
    localparam logic [DW-1:0] RN_MODEA = 8'h69;
    localparam logic [DW-1:0] RN_MODEB = 8'h6A;

    localparam int PB_DTX = 0;
    localparam int PB_DRX = 1;
    localparam int PB_BCH = 4;
    localparam int MUX_BEN = 3;
    localparam int INIT_OFF = 2;

    typedef struct packed {
        logic [GW-1:0] side;
        logic [GW-1:0] ext;
        logic [GW-1:0] rx;
        logic [GW-1:0] tx;
    } gain_set_t;

    function automatic logic is_gain(input logic [DW-1:0] rn);
        return (rn >= RN_GAIN0) && (rn < RN_GAIN0 + DW'(NGAIN));
    endfunction
endpackage

// File: rtl/hbi_regfile.sv
module hbi_regfile
    import hbi_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_wr,
    input  logic          dat_wr,
    input  logic          dat_rd,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output gain_set_t     gains,
    output logic [DW-1:0] mode_a,
    output logic [DW-1:0] mode_b,
    output logic [DW-1:0] init_q,
    output logic [DW-1:0] mux_q
);
    logic [DW-1:0] sel_q;
    logic          hi_q;
    logic [GW-1:0] gword [NGAIN];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            hi_q  <= 1'b0;
        end else if (cmd_wr) begin
            sel_q <= wdata;
            hi_q  <= 1'b0;
        end else if ((dat_wr || dat_rd) && is_gain(sel_q)) begin
            hi_q  <= ~hi_q;
        end
    end

    for (genvar g = 0; g < NGAIN; g++) begin : g_gain
        always_ff @(posedge clk) begin
            if (rst) begin
                gword[g] <= '0;
            end else if (dat_wr && sel_q == RN_GAIN0 + DW'(g)) begin
                if (hi_q) gword[g][GW-1:DW] <= wdata;
                else      gword[g][DW-1:0]  <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_a <= '0;
            mode_b <= '0;
            init_q <= '0;
            mux_q  <= '0;
        end else if (dat_wr) begin
            case (sel_q)
                RN_MODEA: mode_a <= wdata;
                RN_MODEB: mode_b <= wdata;
                RN_INIT:  init_q <= wdata;
                RN_MUX:   mux_q  <= wdata;
                default: ;
            endcase
        end
    end

    assign gains.tx   = gword[0];
    assign gains.rx   = gword[1];
    assign gains.ext  = gword[2];
    assign gains.side = gword[3];

    always_comb begin
        rdata = '0;
        if (is_gain(sel_q)) begin
            for (int g = 0; g < NGAIN; g++)
                if (sel_q == RN_GAIN0 + DW'(g))
                    rdata = hi_q ? gword[g][GW-1:DW] : gword[g][DW-1:0];
        end else begin
            case (sel_q)
                RN_MODEA: rdata = mode_a;
                RN_MODEB: rdata = mode_b;
                RN_INIT:  rdata = init_q;
                RN_MUX:   rdata = mux_q;
                default:  rdata = '0;
            endcase
        end
    end

    AST_CMD_LOW: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> !hi_q); // R2
    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!cmd_wr && (dat_wr || dat_rd) && is_gain(sel_q) && hi_q) |=> !hi_q); // R4
    AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !dat_wr |=> $stable(gains)); // R3
endmodule

// File: rtl/hbi_irq.sv
module hbi_irq
    import hbi_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          evt_dtx,
    input  logic          evt_drx,
    input  logic          tick,
    input  logic          rd_clr,
    input  logic          active,
    input  logic          ints_off,
    input  logic          bch_en,
    output logic [DW-1:0] pend,
    output logic          irq
);
    logic [DW-1:0] set_v;

    always_comb begin
        set_v = '0;
        set_v[PB_DTX] = evt_dtx;
        set_v[PB_DRX] = evt_drx;
        set_v[PB_BCH] = tick;
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (rd_clr ? '0 : pend) | set_v;
    end

    assign irq = active && !ints_off &&
                 (pend[PB_DTX] || pend[PB_DRX] || (pend[PB_BCH] && bch_en));

    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !evt_dtx && !evt_drx && !tick) |=> pend == '0); // R7
    AST_TICK_FLAG: assert property (@(posedge clk) disable iff (rst)
        tick |=> pend[PB_BCH]); // R8
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !evt_dtx && !evt_drx && !tick) |=> !irq); // R10
endmodule

// File: rtl/hbi_bchan.sv
module hbi_bchan
    import hbi_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          tx_wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] rx_in,
    output logic [DW-1:0] rx_buf,
    output logic [DW-1:0] tx_hold
);
    logic [DW-1:0] tx_buf;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_buf  <= '0;
            rx_buf  <= '0;
            tx_hold <= '0;
        end else begin
            if (tx_wr) tx_buf <= wdata;
            if (tick) begin
                rx_buf  <= rx_in;
                tx_hold <= tx_buf;
            end
        end
    end

    AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        tick |=> rx_buf == $past(rx_in)); // R8
    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(tx_hold)); // R8
endmodule

// File: rtl/hbi_top.sv
module hbi_top
    import hbi_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [2:0]    bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          evt_dtx,
    input  logic          evt_drx,
    input  logic          sample_tick,
    input  logic [7:0]    rx_sample,
    output logic [7:0]    tx_hold,
    output logic [15:0]   gain_tx,
    output logic [15:0]   gain_rx,
    output logic [15:0]   gain_ext,
    output logic [15:0]   gain_side,
    output logic [7:0]    mode_a,
    output logic [7:0]    mode_b,
    output logic          irq
);
    logic wr_q, rd_q;
    logic cmd_wr, dat_wr, dat_rd, irq_rd, buf_wr, buf_rd;
    logic [DW-1:0] reg_rdata, pend, rx_buf, init_q, mux_q;
    gain_set_t gains;

    assign wr_q   = bus_sel && bus_wr;
    assign rd_q   = bus_sel && bus_rd && !bus_wr;
    assign cmd_wr = wr_q && bus_addr == OFS_CMD;
    assign dat_wr = wr_q && bus_addr == OFS_DATA;
    assign buf_wr = wr_q && bus_addr == OFS_BBUF;
    assign irq_rd = rd_q && bus_addr == OFS_CMD;
    assign dat_rd = rd_q && bus_addr == OFS_DATA;
    assign buf_rd = rd_q && bus_addr == OFS_BBUF;

    hbi_regfile u_regs (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .dat_wr(dat_wr), .dat_rd(dat_rd),
        .wdata(bus_wdata), .rdata(reg_rdata), .gains(gains),
        .mode_a(mode_a), .mode_b(mode_b), .init_q(init_q), .mux_q(mux_q)
    );

    hbi_irq u_irq (
        .clk(clk), .rst(rst), .evt_dtx(evt_dtx), .evt_drx(evt_drx),
        .tick(sample_tick), .rd_clr(irq_rd),
        .active(init_q[1:0] == 2'b01), .ints_off(init_q[INIT_OFF]),
        .bch_en(mux_q[MUX_BEN]), .pend(pend), .irq(irq)
    );

    hbi_bchan u_bch (
        .clk(clk), .rst(rst), .tick(sample_tick), .tx_wr(buf_wr),
        .wdata(bus_wdata), .rx_in(rx_sample), .rx_buf(rx_buf), .tx_hold(tx_hold)
    );

    always_comb begin
        bus_rdata = '0;
        if (irq_rd)      bus_rdata = pend;
        else if (dat_rd) bus_rdata = reg_rdata;
        else if (buf_rd) bus_rdata = rx_buf;
    end

    assign gain_tx   = gains.tx;
    assign gain_rx   = gains.rx;
    assign gain_ext  = gains.ext;
    assign gain_side = gains.side;

    AST_IRQ_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (u_regs.init_q == 8'h01 || u_regs.init_q[1:0] == 2'b01)); // R9
endmodule

// File: tb/hbi_top_tb.sv
module hbi_top_tb;
    localparam int PERIOD = 10;

    logic clk = 0, rst = 1;
    logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [2:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata, rx_sample = 0, tx_hold, mode_a, mode_b;
    logic evt_dtx = 0, evt_drx = 0, sample_tick = 0, irq;
    logic [15:0] gain_tx, gain_rx, gain_ext, gain_side;
    int total = 0, bad = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    hbi_top u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_dtx(evt_dtx), .evt_drx(evt_drx), .sample_tick(sample_tick),
        .rx_sample(rx_sample), .tx_hold(tx_hold), .gain_tx(gain_tx), .gain_rx(gain_rx),
        .gain_ext(gain_ext), .gain_side(gain_side), .mode_a(mode_a), .mode_b(mode_b),
        .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #(PERIOD/4);
        d = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic tick(input logic [7:0] rx);
        @(negedge clk);
        sample_tick = 1; rx_sample = rx;
        @(negedge clk);
        sample_tick = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 gain_tx", gain_tx, 0);
        check("R1 mode_a", {8'h0, mode_a}, 0);
        check("R1 irq", {15'h0, irq}, 0);
        rd(3'd0, v); check("R1 pending", {8'h0, v}, 0);
        rd(3'd5, v); check("R1 rx buffer", {8'h0, v}, 0);
    endtask

    task automatic t_gains();
        logic [7:0] v;
        wr(0, 8'h63); wr(1, 8'h34); wr(1, 8'h12);
        check("R3 gain_tx", gain_tx, 16'h1234);
        wr(0, 8'h66); wr(1, 8'hCD); wr(1, 8'hAB);
        check("R3 gain_side", gain_side, 16'hABCD);
        wr(0, 8'h64); wr(1, 8'h11); wr(1, 8'h22);
        wr(0, 8'h65); wr(1, 8'h33); wr(1, 8'h44);
        check("R3 gain_rx", gain_rx, 16'h2211);
        check("R3 gain_ext", gain_ext, 16'h4433);
        wr(0, 8'h63); rd(1, v); check("R3 read low", {8'h0, v}, 16'h34);
        rd(1, v); check("R3 read high", {8'h0, v}, 16'h12);
        rd(1, v); check("R4 third read wraps low", {8'h0, v}, 16'h34);
    endtask

    task automatic t_seq();
        wr(0, 8'h64); wr(1, 8'h55);
        wr(0, 8'h64); wr(1, 8'h66);
        check("R2 command resets to low byte", gain_rx, 16'h2266);
        wr(1, 8'h77); wr(1, 8'h88);
        check("R4 third write hits low byte", gain_rx, 16'h7788);
    endtask

    task automatic t_bytes();
        logic [7:0] v;
        wr(0, 8'h69); wr(1, 8'hA5);
        wr(0, 8'h6A); wr(1, 8'h5A);
        check("R5 mode_a", {8'h0, mode_a}, 16'hA5);
        check("R5 mode_b", {8'h0, mode_b}, 16'h5A);
        wr(0, 8'h69); rd(1, v); check("R5 mode_a readback", {8'h0, v}, 16'hA5);
        wr(0, 8'h44); wr(1, 8'h08); rd(1, v); check("R5 mux readback", {8'h0, v}, 16'h08);
        wr(0, 8'h44); wr(1, 8'h00);
    endtask

    task automatic t_unimpl();
        logic [7:0] v;
        wr(0, 8'h6C); wr(1, 8'hFF); wr(1, 8'hEE);
        rd(1, v); check("R6 unimplemented reads zero", {8'h0, v}, 0);
        check("R6 gains untouched", gain_tx ^ gain_rx ^ gain_ext ^ gain_side,
              16'h1234 ^ 16'h7788 ^ 16'h4433 ^ 16'hABCD);
        check("R6 modes untouched", {mode_a, mode_b}, 16'hA55A);
    endtask

    task automatic t_tick();
        logic [7:0] v;
        wr(5, 8'h3C);
        tick(8'hC3);
        check("R8 tx_hold", {8'h0, tx_hold}, 16'h3C);
        rd(5, v); check("R8 rx buffer", {8'h0, v}, 16'hC3);
        @(negedge clk); evt_dtx = 1;
        @(negedge clk); evt_dtx = 0;
        rd(0, v); check("R7 mask", {8'h0, v}, 16'h11);
        rd(0, v); check("R7 cleared", {8'h0, v}, 0);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = 0; evt_drx = 1;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0; evt_drx = 0;
        rd(0, v); check("R7 same-cycle event kept", {8'h0, v}, 16'h02);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(0, 8'h21); wr(1, 8'h01);
        wr(0, 8'h44); wr(1, 8'h08);
        tick(8'h00);
        check("R9 active enabled", {15'h0, irq}, 1);
        wr(0, 8'h21); wr(1, 8'h05);
        check("R9 ints off", {15'h0, irq}, 0);
        wr(1, 8'h00);
        check("R9 idle", {15'h0, irq}, 0);
        wr(1, 8'h01);
        check("R9 active again", {15'h0, irq}, 1);
        wr(0, 8'h44); wr(1, 8'h00);
        check("R9 B source masked", {15'h0, irq}, 0);
        @(negedge clk); evt_dtx = 1;
        @(negedge clk); evt_dtx = 0;
        check("R9 D source unmasked", {15'h0, irq}, 1);
        rd(0, v);
        check("R10 irq released", {15'h0, irq}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_gains();
        t_seq();
        t_bytes();
        t_unimpl();
        t_tick();
        t_irq();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule